// File: doc/BRIEF.md
# Half-Rate Interleaved Shift Register

This block is a serial delay line that accepts one sample on every full-rate clock cycle, yet every storage flip-flop in it is updated only on every other cycle. Incoming samples are dealt alternately to two shift chains. A two-state phase machine decides which chain may shift in each cycle. A multiplexer steered by the same phase merges the chain tails back into one full-rate output stream.

Seen from its ports, the block behaves exactly like a plain full-rate shift register that is twice as deep as one chain. The saving comes only from halving the update rate of each storage element. The design is fully synchronous: the two half-rate clocks become clock enables that take turns every cycle.

The phase machine has two states. EVEN_TURN is the reset state and lets the even chain shift. ODD_TURN lets the odd chain shift. The transition EVEN_TURN→ODD_TURN and the transition ODD_TURN→EVEN_TURN each happen on every clock edge that is not in reset.

Top module: `half_rate_sreg`

## Requirements
- R1: After each rising edge e counted from reset release (the first edge is e=0), `dout` equals the `din` value captured at edge e−2·STAGES_PER_CHAIN+1. This is the behaviour of a plain full-rate shift register with 2·STAGES_PER_CHAIN stages.
- R2: The phase machine enters EVEN_TURN on reset and alternates EVEN_TURN→ODD_TURN→EVEN_TURN on every non-reset edge. Samples captured at even edge numbers therefore go to the even chain, and those at odd edge numbers go to the odd chain.
- R3: Exactly one chain is enabled in each non-reset cycle. A chain that is not enabled keeps all of its stages unchanged. An enabled chain loads `din` into its first stage.
- R4: In EVEN_TURN the output is the last stage of the even chain. In ODD_TURN it is the last stage of the odd chain. The chain whose turn is next is the one selected.
- R5: Synchronous active-high `rst` clears both chains and returns the phase to EVEN_TURN. `dout` is 0 during reset and stays 0 until the first sample has crossed the full depth.
- R6: STAGES_PER_CHAIN is the number of stages in each chain and must be at least 1. With a value of 1, the block acts as a two-cycle delay.
- R7: A reset asserted in the middle of a stream discards every stored sample. Afterwards the output refills from zero exactly as it does after power-up.
- R8: Each sample is DATA_W bits wide, and every bit is delayed the same way and independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Serial sample in, one per cycle |
| dout | output | DATA_W | Delayed sample out, one per cycle |

## Verification
The bench builds two instances. The first has three stages per chain and one-bit samples, which gives a total delay of six. Through it the bench streams every 8-bit sequence back to back, so every window of six consecutive bits passes through the interleaving and the merge. The second has a single stage per chain and four-bit samples. It covers the shortest legal depth and independent bit lanes. Patterns that are non-zero only on even or only on odd edges separate the two chains. A mid-stream reset shows that the fill restarts from zero.

// File: rtl/half_rate_sreg_pkg.sv
package half_rate_sreg_pkg;

    // Whose turn it is to shift; also selects the output tail.
    typedef enum logic {
        EVEN_TURN = 1'b0,
        ODD_TURN  = 1'b1
    } turn_e;

endpackage

// File: rtl/half_rate_sreg_phase.sv
module half_rate_sreg_phase
    import half_rate_sreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output logic  en_even,
    output logic  en_odd,
    output turn_e turn
);

    turn_e state_q;
    turn_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EVEN_TURN: state_d = ODD_TURN;
            ODD_TURN:  state_d = EVEN_TURN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= EVEN_TURN;
        else     state_q <= state_d;
    end

    always_comb begin
        en_even = 1'b0;
        en_odd  = 1'b0;
        unique case (state_q)
            EVEN_TURN: en_even = ~rst;
            ODD_TURN:  en_odd  = ~rst;
        endcase
        turn = state_q;
    end

    // R2: reset lands in EVEN_TURN
    a_r2_reset_even: assert property (@(posedge clk)
        rst |=> (state_q == EVEN_TURN));

    // R2: strict alternation outside reset
    a_r2_even_to_odd: assert property (@(posedge clk) disable iff (rst)
        (state_q == EVEN_TURN) |=> (state_q == ODD_TURN));

    a_r2_odd_to_even: assert property (@(posedge clk) disable iff (rst)
        (state_q == ODD_TURN) |=> (state_q == EVEN_TURN));

endmodule

// File: rtl/half_rate_sreg_chain.sv
module half_rate_sreg_chain #(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] tail
);

    logic [DEPTH-1:0][DATA_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (en) begin
            stage_q[0] <= d_in;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign tail = stage_q[DEPTH-1];

    // R3: an idle chain holds every stage
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(stage_q));

    // R3: an enabled chain captures the input in its head
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        en |=> (stage_q[0] == $past(d_in)));

    // R5: reset empties the chain
    a_r5_chain_clear: assert property (@(posedge clk)
        rst |=> (stage_q == '0));

endmodule

// File: rtl/half_rate_sreg_merge.sv
module half_rate_sreg_merge
    import half_rate_sreg_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  turn_e             turn,
    input  logic [DATA_W-1:0] even_tail,
    input  logic [DATA_W-1:0] odd_tail,
    output logic [DATA_W-1:0] dout
);

    always_comb begin
        dout = even_tail;
        unique case (turn)
            EVEN_TURN: dout = even_tail;
            ODD_TURN:  dout = odd_tail;
        endcase
    end

endmodule

// File: rtl/half_rate_sreg.sv
module half_rate_sreg
    import half_rate_sreg_pkg::*;
#(
    parameter int STAGES_PER_CHAIN = 3,
    parameter int DATA_W           = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // R6: each chain needs at least one stage
    if (STAGES_PER_CHAIN < 1) begin : g_bad_depth
        $error("STAGES_PER_CHAIN must be at least 1");
    end

    logic              en_even;
    logic              en_odd;
    turn_e             turn;
    logic [DATA_W-1:0] even_tail;
    logic [DATA_W-1:0] odd_tail;

    half_rate_sreg_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .en_even (en_even),
        .en_odd  (en_odd),
        .turn    (turn)
    );

    half_rate_sreg_chain #(
        .DEPTH  (STAGES_PER_CHAIN),
        .DATA_W (DATA_W)
    ) u_even (
        .clk  (clk),
        .rst  (rst),
        .en   (en_even),
        .d_in (din),
        .tail (even_tail)
    );

    half_rate_sreg_chain #(
        .DEPTH  (STAGES_PER_CHAIN),
        .DATA_W (DATA_W)
    ) u_odd (
        .clk  (clk),
        .rst  (rst),
        .en   (en_odd),
        .d_in (din),
        .tail (odd_tail)
    );

    half_rate_sreg_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .turn      (turn),
        .even_tail (even_tail),
        .odd_tail  (odd_tail),
        .dout      (dout)
    );

    // R3: exactly one chain shifts per cycle
    a_r3_one_enable: assert property (@(posedge clk) disable iff (rst)
        $countones({en_even, en_odd}) == 1);

    // R5: output is zero right after a reset edge
    a_r5_reset_zero: assert property (@(posedge clk)
        rst |=> (dout == '0));

endmodule

// File: tb/half_rate_sreg_tb.sv
module half_rate_sreg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int KA = 3;
    localparam int WA = 1;
    localparam int KB = 1;
    localparam int WB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WA-1:0] din_a = '0;
    logic [WA-1:0] dout_a;
    logic [WB-1:0] din_b = '0;
    logic [WB-1:0] dout_b;

    int checks = 0;
    int errors = 0;
    int e = 0;
    bit done = 1'b0;
    logic [WA-1:0] ha [0:4095];
    logic [WB-1:0] hb [0:4095];

    always #(CLK_PERIOD/2) clk = ~clk;

    half_rate_sreg #(.STAGES_PER_CHAIN(KA), .DATA_W(WA)) u_dut (
        .clk(clk), .rst(rst), .din(din_a), .dout(dout_a));

    half_rate_sreg #(.STAGES_PER_CHAIN(KB), .DATA_W(WB)) u_dut_k1 (
        .clk(clk), .rst(rst), .din(din_b), .dout(dout_b));

    task automatic check(input string tag, input logic [WB-1:0] act,
                         input logic [WB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s edge=%0d actual=%h expected=%h", tag, e, act, exp);
        end
    endtask

    // Called at a negedge: drive, pass one posedge, check at next negedge.
    task automatic step(input logic [WA-1:0] a, input logic [WB-1:0] b,
                        input string tag_a, input string tag_b);
        logic [WB-1:0] exp_a;
        logic [WB-1:0] exp_b;
        din_a = a;
        din_b = b;
        ha[e] = a;
        hb[e] = b;
        @(negedge clk);
        exp_a = '0;
        exp_b = '0;
        if (e - 2*KA + 1 >= 0) exp_a = WB'(ha[e - 2*KA + 1]);
        if (e - 2*KB + 1 >= 0) exp_b = hb[e - 2*KB + 1];
        check(tag_a, WB'(dout_a), exp_a);
        check(tag_b, dout_b, exp_b);
        e++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: outputs zero while held in reset
        check("R5 reset a", WB'(dout_a), '0);
        check("R5 reset b", dout_b, '0);
        rst = 1'b0;
        e = 0;

        // R5/R6: fill with all ones, zeros until depth crossed
        for (int i = 0; i < 8; i++) step(1'b1, 4'hF, "R5 fill", "R6 fill");

        // R1/R8: every 8-bit sequence streamed back to back
        for (int p = 0; p < 256; p++) begin
            for (int i = 0; i < 8; i++) begin
                logic [7:0] pv;
                pv = 8'(p);
                step(pv[i], pv[3:0] ^ {4{pv[i]}} ^ 4'(i), "R1 sweep", "R8 lanes");
            end
        end

        // R2/R3/R4: ones only on even edges, then only on odd edges
        for (int i = 0; i < 16; i++)
            step((e % 2 == 0) ? 1'b1 : 1'b0, (e % 2 == 0) ? 4'hA : 4'h0,
                 "R3 even only", "R4 even only");
        for (int i = 0; i < 16; i++)
            step((e % 2 == 1) ? 1'b1 : 1'b0, (e % 2 == 1) ? 4'h5 : 4'h0,
                 "R2 odd only", "R4 odd only");

        // R7: mid-stream reset, odd edge count so phase restart matters
        step(1'b1, 4'h9, "R7 pre", "R7 pre");
        rst = 1'b1;
        din_a = 1'b1;
        din_b = 4'hF;
        repeat (2) @(negedge clk);
        check("R7 in reset a", WB'(dout_a), '0);
        check("R7 in reset b", dout_b, '0);
        rst = 1'b0;
        e = 0;
        for (int i = 0; i < 12; i++)
            step(1'(i % 3 != 0), 4'(i + 1), "R7 refill", "R7 refill");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule